// File: doc/BRIEF.md
# Configurable Header Bit Hasher

This preprocessing stage sits on a byte-wide packet stream. Every packet begins with an 8-byte metadata header, and the packet header follows it. For each virtual pipeline, software programs a set of byte selectors. Each selector holds an enable, a byte offset into the packet header, and a bit mask. The block reduces the masked bytes to a 32-bit CRC. It writes the CRC into a fixed field of the metadata header, so later lookup and forwarding stages can act on any header bits. Changing the selection needs only register writes.

The block stores the front of each packet: the metadata plus the selection window. It stores bytes until the packet ends or the window is full, whichever comes first. It then sends out the stored bytes with the hash field replaced. Bytes after the window go straight through with the same handshake. The pipeline number is taken from the low bits of metadata byte 0.

Top module: `hdr_bit_hasher`

## Requirements
- R1: While reset is asserted and just after it, out_valid is 0 and in_ready is 1. Every selector starts disabled, and a packet with no enabled selector gets hash 0x00000000.
- R2: A cycle with cfg_we high writes cfg_en, cfg_off and cfg_mask into selector cfg_slot of pipeline cfg_pipe. A packet that starts after the write uses the new values.
- R3: A packet's pipeline is bits [1:0] of metadata byte 0 (packet byte 0). Header offset 0 is packet byte 8.
- R4: The hash is a CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion. It is taken over the masked bytes of the enabled selectors, sorted by ascending offset. Selectors with equal offsets go in slot-index order.
- R5: Each enabled selector whose offset lies at or past the end of the packet adds one 0x00 byte to the CRC.
- R6: An enabled selector with mask 0x00 adds one 0x00 byte, while a disabled selector adds nothing.
- R7: The hash replaces packet bytes 4 to 7, most significant byte first in byte 4. Every other byte, the byte count and the position of the last flag do not change.
- R8: No output byte of a packet appears until its input has ended or 72 bytes have arrived. Bytes after the 72nd pass through in order.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last hold their values.
- R10: Pipelines are independent: the same packet sent on two differently programmed pipelines gets the hash of each pipeline's own selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Selector write strobe |
| cfg_pipe | input | 2 | Pipeline to write |
| cfg_slot | input | 3 | Selector index to write |
| cfg_en | input | 1 | Selector enable |
| cfg_off | input | 6 | Header byte offset of the selector |
| cfg_mask | input | 8 | Bit mask applied to the selected byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of input packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of output packet |

## Verification
Two things can happen on the same arriving byte. The final header byte of a packet can match a selector, and the packet can end at that byte, so the selectors lying past the end must add their zero bytes in that same cycle. The bench provokes this with a 21-byte packet on a pipeline that has one selector at the last header offset and another past the end. It judges the result by comparing the inserted hash with a CRC that the bench builds from the ordered selector list. Back-pressure during pass-through of long packets is also covered, and there the output must hold steady.

// File: rtl/hdr_bit_hasher.sv
module hdr_bit_hasher #(
  parameter int PIPES = 4,
  parameter int SLOTS = 8,
  parameter int WIN = 64,
  localparam int PW = $clog2(PIPES),
  localparam int SW = $clog2(SLOTS),
  localparam int OW = $clog2(WIN),
  localparam int BUFN = 8 + WIN,
  localparam int CW = $clog2(BUFN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_pipe,
  input  logic [SW-1:0] cfg_slot,
  input  logic          cfg_en,
  input  logic [OW-1:0] cfg_off,
  input  logic [7:0]    cfg_mask,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);

  typedef enum logic [1:0] {FILL, DRAIN, PASS} st_t;

  st_t           st;
  logic [7:0]    mem_q [BUFN];
  logic          sel_en  [PIPES][SLOTS];
  logic [OW-1:0] sel_off [PIPES][SLOTS];
  logic [7:0]    sel_msk [PIPES][SLOTS];
  logic [CW-1:0] cnt, len, rd;
  logic          more;
  logic [PW-1:0] pipe_q;
  logic [31:0]   crc, crc_n, hash;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire [PW-1:0] pipe_now = (cnt == '0) ? in_data[PW-1:0] : pipe_q;
  wire          in_hdr   = cnt >= CW'(8);
  wire [OW-1:0] hoff     = OW'(cnt - CW'(8));
  wire          fill_end = in_last || (cnt == CW'(BUFN - 1));
  wire          rd_end   = rd == len - CW'(1);

  always_comb begin
    crc_n = crc;
    for (int s = 0; s < SLOTS; s++)
      if (in_hdr && sel_en[pipe_now][s] && sel_off[pipe_now][s] == hoff)
        crc_n = crc_step(crc_n, in_data & sel_msk[pipe_now][s]);
    if (in_last)
      for (int s = 0; s < SLOTS; s++)
        if (sel_en[pipe_now][s] && (!in_hdr || sel_off[pipe_now][s] > hoff))
          crc_n = crc_step(crc_n, 8'h00);
  end

  always_ff @(posedge clk)
    if (st == FILL && in_valid) mem_q[cnt] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FILL;
      cnt <= '0;
      len <= '0;
      rd <= '0;
      more <= 1'b0;
      pipe_q <= '0;
      crc <= 32'hFFFFFFFF;
      hash <= '0;
      for (int p = 0; p < PIPES; p++)
        for (int s = 0; s < SLOTS; s++) begin
          sel_en[p][s] <= 1'b0;
          sel_off[p][s] <= '0;
          sel_msk[p][s] <= '0;
        end
    end else begin
      if (cfg_we) begin
        sel_en[cfg_pipe][cfg_slot] <= cfg_en;
        sel_off[cfg_pipe][cfg_slot] <= cfg_off;
        sel_msk[cfg_pipe][cfg_slot] <= cfg_mask;
      end
      case (st)
        FILL: if (in_valid) begin
          if (cnt == '0) pipe_q <= in_data[PW-1:0];
          crc <= crc_n;
          if (fill_end) begin
            len <= cnt + CW'(1);
            more <= !in_last;
            hash <= ~crc_n;
            rd <= '0;
            st <= DRAIN;
          end else cnt <= cnt + CW'(1);
        end
        DRAIN: if (out_ready) begin
          if (rd_end) begin
            st <= more ? PASS : FILL;
            cnt <= '0;
            crc <= 32'hFFFFFFFF;
          end else rd <= rd + CW'(1);
        end
        PASS: if (in_valid && out_ready && in_last) st <= FILL;
        default: st <= FILL;
      endcase
    end
  end

  logic [7:0] hbyte;
  always_comb
    case (rd)
      CW'(4):  hbyte = hash[31:24];
      CW'(5):  hbyte = hash[23:16];
      CW'(6):  hbyte = hash[15:8];
      CW'(7):  hbyte = hash[7:0];
      default: hbyte = mem_q[rd];
    endcase

  assign in_ready  = (st == FILL) || (st == PASS && out_ready);
  assign out_valid = (st == DRAIN) || (st == PASS && in_valid);
  assign out_data  = (st == PASS) ? in_data : hbyte;
  assign out_last  = (st == DRAIN) ? (rd_end && !more) : (st == PASS && in_last);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    st == FILL |-> !out_valid);

  a_r8_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    st == DRAIN |-> !in_ready);

  a_r7_hash_kept: assert property (@(posedge clk) disable iff (!rst_n)
    st == DRAIN |=> st != DRAIN || $stable(hash));

  a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
    st == FILL && in_valid && cnt == CW'(BUFN - 1) |=> st == DRAIN);

endmodule

// File: tb/hdr_bit_hasher_test.sv
`timescale 1ns/100ps
module hdr_bit_hasher_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0;
  logic [1:0] cfg_pipe = 0;
  logic [2:0] cfg_slot = 0;
  logic [5:0] cfg_off = 0;
  logic [7:0] cfg_mask = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  hdr_bit_hasher uut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] txb [0:255];
  logic [7:0] rxb [0:255];
  int rxn, stall_bad;
  bit last_ok;
  logic [31:0] got_hash;
  bit m_en [4][8];
  logic [5:0] m_off [4][8];
  logic [7:0] m_msk [4][8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] exp_hash(input int p, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int o = 0; o < 64; o++)
      for (int s = 0; s < 8; s++)
        if (m_en[p][s] && m_off[p][s] == 6'(o))
          c = step(c, (8 + o < len) ? (txb[8 + o] & m_msk[p][s]) : 8'h00);
    return ~c;
  endfunction

  task automatic cfgw(input int p, input int s, input bit en, input int off, input logic [7:0] msk);
    @(negedge clk);
    cfg_we = 1; cfg_pipe = 2'(p); cfg_slot = 3'(s); cfg_en = en; cfg_off = 6'(off); cfg_mask = msk;
    @(negedge clk);
    cfg_we = 0;
    m_en[p][s] = en; m_off[p][s] = 6'(off); m_msk[p][s] = msk;
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      bit acc;
      do begin
        @(negedge clk);
        in_valid = 1; in_data = txb[i]; in_last = (i == len - 1);
        #1 acc = in_ready;
      end while (!acc);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic recv(input bit bp);
    bit done = 0, pstall = 0;
    logic [7:0] pd = 0;
    logic pl = 0;
    rxn = 0; stall_bad = 0; last_ok = 1;
    while (!done) begin
      @(negedge clk);
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (pstall && !(out_valid && out_data == pd && out_last == pl)) stall_bad++;
      pstall = out_valid && !out_ready; pd = out_data; pl = out_last;
      if (out_valid && out_ready) begin
        rxb[rxn] = out_data;
        if (out_last) done = 1;
        rxn++;
        if (rxn > 250) begin last_ok = 0; done = 1; end
      end
    end
    out_ready = 1;
  endtask

  task automatic run_pkt(input int p, input int len, input int seed, input bit bp, input string tag);
    logic [31:0] eh;
    int diff = 0;
    for (int i = 0; i < len; i++) txb[i] = 8'(seed * 37 + i * 11 + (i >> 3));
    txb[0] = {txb[0][7:2], 2'(p)};
    eh = exp_hash(p, len);
    fork
      send(len);
      recv(bp);
    join
    got_hash = {rxb[4], rxb[5], rxb[6], rxb[7]};
    for (int i = 0; i < rxn && i < len; i++)
      if (!(i >= 4 && i < 8) && rxb[i] != txb[i]) diff++;
    check(rxn == len && last_ok, {tag, " R7 length/last"}, rxn, len);
    check(got_hash == eh, {tag, " R4 R7 hash field"}, got_hash, eh);
    check(diff == 0, {tag, " R7 R8 untouched bytes"}, diff, 0);
    if (bp) check(stall_bad == 0, {tag, " R9 stall stable"}, stall_bad, 0);
  endtask

  localparam logic [18:0] VEC [10] = '{
    {2'd0, 8'd40, 8'd1, 1'b0}, {2'd0, 8'd21, 8'd2, 1'b0},
    {2'd1, 8'd72, 8'd3, 1'b0}, {2'd1, 8'd100, 8'd4, 1'b1},
    {2'd1, 8'd30, 8'd5, 1'b0}, {2'd2, 8'd16, 8'd6, 1'b0},
    {2'd3, 8'd50, 8'd7, 1'b0}, {2'd0, 8'd8, 8'd8, 1'b0},
    {2'd2, 8'd200, 8'd9, 1'b1}, {2'd1, 8'd9, 8'd10, 1'b0}};

  initial begin
    logic [31:0] h0;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++) begin m_en[p][s] = 0; m_off[p][s] = 0; m_msk[p][s] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    run_pkt(0, 30, 11, 0, "R1 unconfigured");
    check(got_hash == 0, "R1 empty selection hash", got_hash, 0);

    cfgw(0, 0, 1, 12, 8'hFF); cfgw(0, 1, 1, 2, 8'hFF);
    cfgw(0, 2, 1, 2, 8'h0F); cfgw(0, 3, 1, 30, 8'hF0);
    cfgw(1, 0, 1, 60, 8'hFF);
    for (int s = 1; s < 8; s++) cfgw(1, s, 1, 22 + s, 8'hFF);
    cfgw(2, 4, 1, 5, 8'h00);

    foreach (VEC[i])
      run_pkt(int'(VEC[i][18:17]), int'(VEC[i][16:9]), int'(VEC[i][8:1]), VEC[i][0], "R3 R4 table");

    run_pkt(1, 30, 20, 0, "R5 beyond end");
    run_pkt(2, 16, 21, 0, "R6 zero mask");
    check(got_hash != 32'h0, "R6 zero mask differs from empty", got_hash, 1);
    run_pkt(0, 60, 22, 0, "R10 pipe0");
    h0 = got_hash;
    run_pkt(1, 60, 22, 0, "R10 pipe1");
    check(got_hash != h0, "R10 pipelines independent", got_hash, ~h0);
    run_pkt(0, 120, 23, 1, "R9 backpressure");
    cfgw(3, 7, 1, 0, 8'hFF);
    run_pkt(3, 20, 24, 0, "R2 reprogrammed");
    check(got_hash != 32'h0, "R2 new selection applied", got_hash, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule